// File: doc/BRIEF.md
# Supply Voltage Event Monitor

This block captures supply-droop events from two external comparators: a severe "detect" level and an earlier "warning" level. It hands them to software through three byte-wide registers on a simple register bus. Each comparator output passes through a flip-flop synchronizer and then sets a sticky flag. The flag stays set until software acknowledges it. Depending on its enable bits, a set flag raises a shared interrupt line or, for the detect flag only, a system reset request.

The block also drives the comparator trip-point selections. It holds the bandgap and low-power option bits for a regulator and presents the regulator's run-regulation status. It lets software release pad isolation by writing an acknowledge bit, which produces a one-cycle release pulse.

Reads are combinational from the address. Writes take effect at the clock edge on which the write enable is high.

Top module: `lvd_supervisor`

## Requirements
- R1: After reset, the registers at offsets 0, 1, 2 and 3 read 0x00, and irq_o, rst_req_o, iso_release_o and all trip and bandgap outputs are low, provided the status inputs are low.
- R2: Offset 0 keeps the trip select in bits 1:0, the reset enable in bit 4 and the interrupt enable in bit 5. Offset 1 keeps the trip select in bits 1:0 and the interrupt enable in bit 5. These fields read back as written and drive det_trip_o and warn_trip_o.
- R3: The detect and warning flags read in bit 7 of offsets 0 and 1. A flag becomes 1 three clock edges after its event input rises (two synchronizer stages plus the flag flop). It stays 1 after the input falls.
- R4: Writing 1 to bit 6 of a flag's register clears that flag when its synchronized event is low. Writing 0 to bit 6 leaves the flag unchanged.
- R5: When an acknowledge write falls in a cycle where the synchronized event is still high, the flag stays 1, because set wins over clear.
- R6: irq_o is high exactly when some flag is 1 with its interrupt enable (bit 5) set. Clearing the enable drops irq_o without clearing the flag.
- R7: rst_req_o is high exactly when the detect flag and its reset enable (offset 0 bit 4) are both 1. The warning flag never causes a reset request, and offset 1 bit 4 reads 0.
- R8: Bit 7 and bit 6 ignore written values. Acknowledge bits and unused bits (offset 0 bits 3:2 and 6; offset 1 bits 4:2 and 6; offset 2 bits 1, 5, 7) read 0, so writing 0xFF reads back 0x33, 0x23 and 0x51 respectively with status inputs low.
- R9: Offset 2 bit 0 drives bg_buf_en_o, bit 4 drives bg_lp_en_o and bit 6 holds the low-power option. lp_unrestricted_o is high only when bits 6 and 4 are both set.
- R10: Offset 2 bit 2 reads the reg_run_in input and bit 3 reads the iso_active_in input.
- R11: A write with bit 3 set to offset 2 makes iso_release_o high for exactly the one cycle following that write edge.
- R12: Offset 3 reads 0x00, and writes to it change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| det_in | input | 1 | Detect comparator output (asynchronous) |
| warn_in | input | 1 | Warning comparator output (asynchronous) |
| reg_run_in | input | 1 | Regulator is in run regulation |
| iso_active_in | input | 1 | Pads and peripherals are isolated |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request |
| det_trip_o | output | 2 | Detect trip-point select |
| warn_trip_o | output | 2 | Warning trip-point select |
| bg_buf_en_o | output | 1 | Bandgap buffer enable |
| bg_lp_en_o | output | 1 | Bandgap enable in low-power modes |
| lp_unrestricted_o | output | 1 | Low-power frequency limits lifted |
| iso_release_o | output | 1 | One-cycle isolation release pulse |

## Verification
The two functions that can fall in one cycle are a synchronized event setting a flag and a software acknowledge clearing the same flag. The bench provokes this by holding the comparator input high across the acknowledge write. It judges the outcome from the flag read back at bit 7 and from irq_o and rst_req_o. It then repeats the acknowledge once the event has left the synchronizer, to show that the clear path works when it does not collide with a set.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
   localparam int REG_W     = 8;
   localparam int N_EVT     = 2;
   localparam int EVT_DET   = 0;
   localparam int EVT_WARN  = 1;

   // register byte offsets, detect then warning then regulator
   localparam int OFS_DET   = 0;
   localparam int OFS_WARN  = 1;
   localparam int OFS_REGU  = 2;

   // event register fields
   localparam int B_TRIP_LO = 0;
   localparam int B_TRIP_HI = 1;
   localparam int B_RST_EN  = 4;
   localparam int B_IRQ_EN  = 5;
   localparam int B_ACK     = 6;
   localparam int B_FLAG    = 7;

   // regulator register fields
   localparam int B_BGBUF   = 0;
   localparam int B_RUN     = 2;
   localparam int B_ISO     = 3;
   localparam int B_BGLP    = 4;
   localparam int B_LPOPT   = 6;

   typedef struct packed {
      logic [1:0] trip;
      logic       irq_en;
      logic       rst_en;
   } evt_ctl_t;
endpackage

// File: rtl/lvd_sync_chain.sv
module lvd_sync_chain #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lvd_sync_chain: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lvd_sync_chain: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lvd_sticky_flag.sv
module lvd_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   // set dominates clear when both land on one edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/lvd_supervisor.sv
module lvd_supervisor
   import lvd_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              det_in,
   input  logic              warn_in,
   input  logic              reg_run_in,
   input  logic              iso_active_in,
   output logic              irq_o,
   output logic              rst_req_o,
   output logic [1:0]        det_trip_o,
   output logic [1:0]        warn_trip_o,
   output logic              bg_buf_en_o,
   output logic              bg_lp_en_o,
   output logic              lp_unrestricted_o,
   output logic              iso_release_o
);
   localparam int N_REGS = 3;
   localparam logic [ADDR_W-1:0] A_REGU = ADDR_W'(OFS_REGU);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("lvd_supervisor: ADDR_W too small for three registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lvd_supervisor: SYNC_STAGES must be at least 2");
   end
   if (N_REGS > (1 << ADDR_W)) begin : g_bad_map
      $error("lvd_supervisor: address space smaller than register map");
   end

   logic [N_EVT-1:0]       evt_raw;
   logic [N_EVT-1:0]       evt_sync;
   logic [N_EVT-1:0]       ack_wr;
   logic [N_EVT-1:0]       flag;
   logic [N_EVT-1:0]       irq_en;
   logic [N_EVT-1:0]       rst_en;
   logic [N_EVT-1:0][1:0]  trip;
   logic [N_EVT-1:0][7:0]  rd_evt;

   assign evt_raw[EVT_DET]  = det_in;
   assign evt_raw[EVT_WARN] = warn_in;

   lvd_sync_chain #(
      .WIDTH  (N_EVT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (evt_raw),
      .q_o   (evt_sync)
   );

   for (genvar e = 0; e < N_EVT; e++) begin : g_evt
      localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(OFS_DET + e);
      localparam bit HAS_RST = (e == EVT_DET);

      evt_ctl_t ctl_q;
      logic     hit;

      assign hit       = bus_we && (bus_addr == MY_OFS);
      assign ack_wr[e] = hit && bus_wdata[B_ACK];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_q <= '0;
         end else if (hit) begin
            ctl_q.trip   <= bus_wdata[B_TRIP_HI:B_TRIP_LO];
            ctl_q.irq_en <= bus_wdata[B_IRQ_EN];
            ctl_q.rst_en <= HAS_RST ? bus_wdata[B_RST_EN] : 1'b0;
         end
      end

      lvd_sticky_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (evt_sync[e]),
         .clr_i  (ack_wr[e]),
         .flag_o (flag[e])
      );

      assign irq_en[e] = ctl_q.irq_en;
      assign rst_en[e] = ctl_q.rst_en;
      assign trip[e]   = ctl_q.trip;

      always_comb begin
         rd_evt[e]                      = '0;
         rd_evt[e][B_TRIP_HI:B_TRIP_LO] = ctl_q.trip;
         rd_evt[e][B_RST_EN]            = ctl_q.rst_en;
         rd_evt[e][B_IRQ_EN]            = ctl_q.irq_en;
         rd_evt[e][B_FLAG]              = flag[e];
      end
   end

   // regulator register
   logic regu_hit;
   logic bgbuf_q, bglp_q, lpopt_q, iso_rel_q;
   logic iso_wr;

   assign regu_hit = bus_we && (bus_addr == A_REGU);
   assign iso_wr   = regu_hit && bus_wdata[B_ISO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bgbuf_q <= 1'b0;
         bglp_q  <= 1'b0;
         lpopt_q <= 1'b0;
      end else if (regu_hit) begin
         bgbuf_q <= bus_wdata[B_BGBUF];
         bglp_q  <= bus_wdata[B_BGLP];
         lpopt_q <= bus_wdata[B_LPOPT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) iso_rel_q <= 1'b0;
      else        iso_rel_q <= iso_wr;
   end

   logic [7:0] rd_regu;
   always_comb begin
      rd_regu          = '0;
      rd_regu[B_BGBUF] = bgbuf_q;
      rd_regu[B_RUN]   = reg_run_in;
      rd_regu[B_ISO]   = iso_active_in;
      rd_regu[B_BGLP]  = bglp_q;
      rd_regu[B_LPOPT] = lpopt_q;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      for (int e = 0; e < N_EVT; e++) begin
         if (bus_addr == ADDR_W'(OFS_DET + e)) bus_rdata = rd_evt[e];
      end
      if (bus_addr == A_REGU) bus_rdata = rd_regu;
   end

   assign irq_o             = |(flag & irq_en);
   assign rst_req_o         = |(flag & rst_en);
   assign det_trip_o        = trip[EVT_DET];
   assign warn_trip_o       = trip[EVT_WARN];
   assign bg_buf_en_o       = bgbuf_q;
   assign bg_lp_en_o        = bglp_q;
   assign lp_unrestricted_o = lpopt_q && bglp_q;
   assign iso_release_o     = iso_rel_q;

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[7], bus_wdata[3:2]};
endmodule

// File: rtl/lvd_supervisor_chk.sv
module lvd_supervisor_chk
   import lvd_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [N_EVT-1:0] evt_sync,
   input logic [N_EVT-1:0] ack_wr,
   input logic [N_EVT-1:0] flag,
   input logic             iso_wr,
   input logic             iso_release_o,
   input logic             irq_o,
   input logic             rst_req_o
);
   // R3
   det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag[EVT_DET] && !ack_wr[EVT_DET] |=> flag[EVT_DET]);

   // R3
   warn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[EVT_WARN]) |-> $past(evt_sync[EVT_WARN]));

   // R4
   det_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr[EVT_DET] && !evt_sync[EVT_DET] |=> !flag[EVT_DET]);

   // R5
   det_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_sync[EVT_DET] |=> flag[EVT_DET]);

   // R5
   warn_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_sync[EVT_WARN] |=> flag[EVT_WARN]);

   // R6
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flag != '0));

   // R7
   rst_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> flag[EVT_DET]);

   // R11
   iso_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iso_wr |=> iso_release_o);

   // R11
   iso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iso_wr |=> !iso_release_o);
endmodule

bind lvd_supervisor lvd_supervisor_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .evt_sync      (evt_sync),
   .ack_wr        (ack_wr),
   .flag          (flag),
   .iso_wr        (iso_wr),
   .iso_release_o (iso_release_o),
   .irq_o         (irq_o),
   .rst_req_o     (rst_req_o)
);

// File: tb/lvd_supervisor_tb.sv
`timescale 1ns/1ps
module lvd_supervisor_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       det = 1'b0, warn = 1'b0, run = 1'b0, iso = 1'b0;
   logic       irq, rreq, bgbuf, bglp, unres, rel;
   logic [1:0] dtrip, wtrip;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   lvd_supervisor u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .det_in(det), .warn_in(warn),
      .reg_run_in(run), .iso_active_in(iso), .irq_o(irq), .rst_req_o(rreq),
      .det_trip_o(dtrip), .warn_trip_o(wtrip), .bg_buf_en_o(bgbuf),
      .bg_lp_en_o(bglp), .lp_unrestricted_o(unres), .iso_release_o(rel)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a; #1;
      d = rdata;
   endtask

   task automatic settle;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic drive_evt(input logic is_det, input logic v);
      @(negedge clk);
      if (is_det) det = v; else warn = v;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R1 reg after reset", d, 8'h00);
      end
      chk("R1 outputs after reset", {irq, rreq, rel, bgbuf, bglp, unres, dtrip}, 8'h00);
      chk("R1 warn trip after reset", {6'b0, wtrip}, 8'h00);
   endtask

   task automatic t_fields;
      logic [7:0] d;
      wr(2'd0, 8'h31); rd(2'd0, d);
      chk("R2 detect fields", d, 8'h31);
      chk("R2 det_trip_o", {6'b0, dtrip}, 8'h01);
      wr(2'd1, 8'h22); rd(2'd1, d);
      chk("R2 warning fields", d, 8'h22);
      chk("R2 warn_trip_o", {6'b0, wtrip}, 8'h02);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
   endtask

   task automatic t_sticky_ack;
      logic [7:0] d;
      drive_evt(1'b1, 1'b1);
      repeat (2) @(posedge clk); #1;
      rd(2'd0, d);
      chk("R3 flag not yet set after two edges", d, 8'h00);
      @(posedge clk); #1;
      rd(2'd0, d);
      chk("R3 detect flag set on third edge", d, 8'h80);
      drive_evt(1'b1, 1'b0);
      settle();
      rd(2'd0, d);
      chk("R3 flag sticky after input falls", d, 8'h80);
      wr(2'd0, 8'h00); rd(2'd0, d);
      chk("R4 zero ack keeps flag", d, 8'h80);
      wr(2'd0, 8'h40); rd(2'd0, d);
      chk("R4 ack clears detect flag", d, 8'h00);
   endtask

   task automatic t_set_priority;
      logic [7:0] d;
      drive_evt(1'b0, 1'b1);
      settle();
      wr(2'd1, 8'h60); rd(2'd1, d);
      chk("R5 set wins over ack", d, 8'ha0);
      chk("R5 irq stays with flag", {7'b0, irq}, 8'h01);
      drive_evt(1'b0, 1'b0);
      settle();
      wr(2'd1, 8'h40); rd(2'd1, d);
      chk("R5 ack after event gone clears", d, 8'h00);
      chk("R5 irq drops after clear", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_irq;
      logic [7:0] d;
      wr(2'd1, 8'h20);
      chk("R6 no irq without flag", {7'b0, irq}, 8'h00);
      drive_evt(1'b0, 1'b1);
      settle();
      chk("R6 warning irq", {7'b0, irq}, 8'h01);
      wr(2'd1, 8'h00); rd(2'd1, d);
      chk("R6 enable off drops irq", {7'b0, irq}, 8'h00);
      chk("R6 flag kept when enable off", d, 8'h80);
      drive_evt(1'b0, 1'b0);
      settle();
      wr(2'd1, 8'h40);
      wr(2'd0, 8'h20);
      drive_evt(1'b1, 1'b1);
      settle();
      chk("R6 detect irq", {6'b0, irq, rreq}, 8'h02);
      drive_evt(1'b1, 1'b0);
      settle();
      wr(2'd0, 8'h40);
      chk("R6 cleared", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_reset_req;
      logic [7:0] d;
      wr(2'd0, 8'h10);
      chk("R7 no request without flag", {7'b0, rreq}, 8'h00);
      drive_evt(1'b1, 1'b1);
      settle();
      chk("R7 reset request, no irq", {6'b0, irq, rreq}, 8'h01);
      wr(2'd0, 8'h00);
      chk("R7 enable off drops request", {7'b0, rreq}, 8'h00);
      drive_evt(1'b1, 1'b0);
      settle();
      wr(2'd0, 8'h40);
      wr(2'd1, 8'h10);
      rd(2'd1, d);
      chk("R7 warning bit 4 reads 0", d, 8'h00);
      drive_evt(1'b0, 1'b1);
      settle();
      chk("R7 warning flag gives no request", {7'b0, rreq}, 8'h00);
      drive_evt(1'b0, 1'b0);
      settle();
      wr(2'd1, 8'h40);
   endtask

   task automatic t_readonly;
      logic [7:0] d;
      wr(2'd0, 8'hff); rd(2'd0, d);
      chk("R8 detect 0xFF readback", d, 8'h33);
      wr(2'd1, 8'hff); rd(2'd1, d);
      chk("R8 warning 0xFF readback", d, 8'h23);
      wr(2'd2, 8'hff); rd(2'd2, d);
      chk("R8 regulator 0xFF readback", d, 8'h51);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
   endtask

   task automatic t_regulator;
      wr(2'd2, 8'h40);
      chk("R9 option alone", {5'b0, bgbuf, bglp, unres}, 8'h00);
      wr(2'd2, 8'h10);
      chk("R9 bandgap alone", {5'b0, bgbuf, bglp, unres}, 8'h02);
      wr(2'd2, 8'h51);
      chk("R9 both set", {5'b0, bgbuf, bglp, unres}, 8'h07);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_status;
      logic [7:0] d;
      run = 1'b1; rd(2'd2, d);
      chk("R10 run status bit 2", d, 8'h04);
      run = 1'b0; iso = 1'b1; rd(2'd2, d);
      chk("R10 isolation bit 3", d, 8'h08);
      wr(2'd2, 8'h04); rd(2'd2, d);
      chk("R10 write to status bit ignored", d, 8'h08);
      iso = 1'b0;
   endtask

   task automatic t_iso_release;
      chk("R11 idle release low", {7'b0, rel}, 8'h00);
      wr(2'd2, 8'h08);
      chk("R11 release pulse high", {7'b0, rel}, 8'h01);
      @(posedge clk); #1;
      chk("R11 release pulse one cycle", {7'b0, rel}, 8'h00);
   endtask

   task automatic t_unmapped;
      logic [7:0] d;
      wr(2'd0, 8'h12);
      wr(2'd3, 8'hff);
      rd(2'd3, d);
      chk("R12 unmapped reads zero", d, 8'h00);
      rd(2'd0, d);
      chk("R12 unmapped write no effect", d, 8'h12);
      chk("R12 outputs unchanged", {irq, rreq, rel, bgbuf, bglp, unres, wtrip}, 8'h00);
      wr(2'd0, 8'h00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_fields();
      t_sticky_ack();
      t_set_priority();
      t_irq();
      t_reset_req();
      t_readonly();
      t_regulator();
      t_status();
      t_iso_release();
      t_unmapped();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule